// File: doc/BRIEF.md
# Memory Lane Unit with Link Reservation

This block sits between an execution core and a 32-bit, word-addressed data memory. For each accepted request it forms the byte address by adding a base register value to a sign-extended 16-bit offset. It then drives the word index, byte enables and lane-steered write data to the memory in that same cycle. Sub-word loads come back one cycle later. The unit picks the addressed byte or halfword out of the returned word, zero-extends it and writes it to the destination register index.

A one-entry reservation supports an atomic read-modify-write pair. A link load behaves as a full-word load and also records the word index it touched. A later conditional store writes memory only while that reservation is still standing. It always reports the outcome to its destination register: 1 on success, 0 on failure. The reservation is dropped by three events: a plain store to the same word, a pulse on the external invalidate input, or any conditional store.

A small three-state machine tracks which writeback is due in the current cycle. `ST_IDLE` means no writeback. `ST_LOAD_RET` returns aligned load data. `ST_COND_RET` returns the conditional-store flag. From any state, an accepted load or link load moves to `ST_LOAD_RET`, an accepted conditional store moves to `ST_COND_RET`, and anything else moves to `ST_IDLE`. Requests may be issued on every cycle.

Top module: `lane_lsu`

## Requirements
- R1: Opcode values are 0x24 byte load, 0x25 halfword load, 0x23 word load, 0x28 byte store, 0x29 halfword store, 0x2b word store, 0x30 link load and 0x38 conditional store. For an accepted request, `mem_en` rises in the same cycle with `mem_addr` equal to bits [WADDR_W+1:2] of `req_base` plus the 16-bit offset sign-extended from its bit 15.
- R2: A byte store asserts `mem_we` with exactly one enable bit set, bit number = address bits [1:0] (lane k is data bits 8k+7:8k, little-endian). Write data carries source bits 7:0 in every lane.
- R3: A halfword store asserts `mem_we` with enables 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. Write data is source bits 15:0 in both halves.
- R4: A word store asserts `mem_we`, enables 4'b1111 and write data equal to the source value.
- R5: Every load leaves `mem_we` low. In the following cycle the load raises `wb_en` with `wb_dst` equal to the request's destination index. A word load or link load returns the full read word. Back-to-back requests each get their own writeback.
- R6: A byte load returns the read-data lane selected by address bits [1:0] in bits 7:0, with zeros in bits 31:8.
- R7: A halfword load returns read bits 31:16 when address bit 1 is 1, otherwise bits 15:0, with zeros in bits 31:16.
- R8: A link load sets the reservation on its word index. A conditional store succeeds only if three conditions hold: the reservation is valid, the word index matches (indices compare in WADDR_W bits), and no invalidate pulse arrives in the same cycle. On success it writes the word like a word store, and one cycle later `wb_data` is 1.
- R9: A failed conditional store keeps `mem_en` and `mem_we` low. One cycle later it still raises `wb_en` with `wb_data` equal to 0.
- R10: Every conditional store, successful or not, clears the reservation.
- R11: A byte, halfword or word store to the reserved word index clears the reservation. A store to another word index leaves it intact.
- R12: An invalidate pulse clears the reservation. When a link load arrives in the same cycle, the link load wins and the reservation is set.
- R13: With `req_valid` low, or with an opcode outside the list in R1, the unit leaves `mem_en` low, raises no writeback in the next cycle and leaves the reservation unchanged.
- R14: After reset there is no reservation, `mem_en` is low and `wb_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Operation code |
| req_base | input | 32 | Base register value |
| req_src | input | 32 | Store source register value |
| req_ofs | input | 16 | Signed address offset |
| req_dst | input | RIDX_W | Destination register index for writeback |
| resv_kill | input | 1 | External reservation invalidate pulse |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | WADDR_W | Memory word index |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| wb_en | output | 1 | Register writeback strobe |
| wb_dst | output | RIDX_W | Writeback register index |
| wb_data | output | 32 | Writeback value |

## Verification
The bench builds the unit with WADDR_W = 8 and RIDX_W = 5, so the memory model holds 256 words. With that width, word indices wrap at 1 KiB of byte address. The bench therefore drives two byte addresses 0x400 apart and expects them to alias onto one reservation, confirming that the link compare uses the truncated index. It also uses offsets of both signs to show that the top offset bit extends into the address sum.

// File: rtl/lane_lsu_pkg.sv
package lane_lsu_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam logic [5:0] OPC_LBU = 6'h24;
    localparam logic [5:0] OPC_LHU = 6'h25;
    localparam logic [5:0] OPC_LW  = 6'h23;
    localparam logic [5:0] OPC_SB  = 6'h28;
    localparam logic [5:0] OPC_SH  = 6'h29;
    localparam logic [5:0] OPC_SW  = 6'h2b;
    localparam logic [5:0] OPC_LL  = 6'h30;
    localparam logic [5:0] OPC_SC  = 6'h38;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOAD_RET = 2'd1,
        ST_COND_RET = 2'd2
    } ret_state_e;

    typedef struct packed {
        logic      legal;
        logic      is_load;
        logic      is_store;
        logic      is_cond;
        logic      is_link;
        acc_size_e size;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [5:0] op);
        op_dec_t d;
        d      = '0;
        d.size = ACC_WORD;
        case (op)
            OPC_LBU: begin d.legal = 1'b1; d.is_load  = 1'b1; d.size = ACC_BYTE; end
            OPC_LHU: begin d.legal = 1'b1; d.is_load  = 1'b1; d.size = ACC_HALF; end
            OPC_LW:  begin d.legal = 1'b1; d.is_load  = 1'b1; end
            OPC_LL:  begin d.legal = 1'b1; d.is_load  = 1'b1; d.is_link = 1'b1; end
            OPC_SB:  begin d.legal = 1'b1; d.is_store = 1'b1; d.size = ACC_BYTE; end
            OPC_SH:  begin d.legal = 1'b1; d.is_store = 1'b1; d.size = ACC_HALF; end
            OPC_SW:  begin d.legal = 1'b1; d.is_store = 1'b1; end
            OPC_SC:  begin d.legal = 1'b1; d.is_store = 1'b1; d.is_cond = 1'b1; end
            default: d = d;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lane_agen.sv
module lane_agen #(
    parameter int WADDR_W = 30
) (
    input  logic [31:0]        base,
    input  logic [15:0]        ofs,
    output logic [WADDR_W-1:0] word_idx,
    output logic [1:0]         lane_off
);
    logic [31:0] ea;

    // byte address: base plus offset extended from its sign bit (R1)
    assign ea       = base + {{16{ofs[15]}}, ofs};
    assign word_idx = ea[WADDR_W+1:2];
    assign lane_off = ea[1:0];

    generate
        if (WADDR_W < 30) begin : g_trim
            logic unused_hi;
            assign unused_hi = ^ea[31:WADDR_W+2];
        end
    endgenerate
endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer
    import lane_lsu_pkg::*;
(
    input  acc_size_e         size,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    logic is_byte;
    logic is_half;

    assign is_byte = (size == ACC_BYTE);
    assign is_half = (size == ACC_HALF);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            localparam logic [1:0] LANE_ID = 2'(k);
            assign be[k] = is_byte ? (off == LANE_ID)
                         : is_half ? (off[1] == LANE_ID[1])
                         : 1'b1;
            assign wdata[8*k +: 8] = is_byte ? src[7:0]
                                   : is_half ? src[8*(k%2) +: 8]
                                   : src[8*k +: 8];
        end
    endgenerate
endmodule

// File: rtl/lane_load_align.sv
module lane_load_align
    import lane_lsu_pkg::*;
(
    input  acc_size_e         size,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value
);
    logic [7:0]  pick_byte;
    logic [15:0] pick_half;

    assign pick_byte = rdata[8*off +: 8];
    assign pick_half = off[1] ? rdata[31:16] : rdata[15:0];

    always_comb begin
        unique case (size)
            ACC_BYTE: value = {24'b0, pick_byte};
            ACC_HALF: value = {16'b0, pick_half};
            default:  value = rdata;
        endcase
    end
endmodule

// File: rtl/lane_resv.sv
module lane_resv #(
    parameter int WADDR_W = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_set,
    input  logic               cond_fire,
    input  logic               plain_store,
    input  logic               kill,
    input  logic [WADDR_W-1:0] probe,
    output logic               valid,
    output logic               hit
);
    logic               valid_q;
    logic [WADDR_W-1:0] addr_q;

    assign valid = valid_q;
    assign hit   = valid_q && (addr_q == probe);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (link_set) begin
            valid_q <= 1'b1;
            addr_q  <= probe;
        end else if (kill || cond_fire || (plain_store && hit)) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lane_lsu.sv
module lane_lsu
    import lane_lsu_pkg::*;
#(
    parameter int WADDR_W = 30,
    parameter int RIDX_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [5:0]         req_op,
    input  logic [31:0]        req_base,
    input  logic [31:0]        req_src,
    input  logic [15:0]        req_ofs,
    input  logic [RIDX_W-1:0]  req_dst,
    input  logic               resv_kill,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    output logic               wb_en,
    output logic [RIDX_W-1:0]  wb_dst,
    output logic [31:0]        wb_data
);
    op_dec_t            dec;
    logic               req_ok;
    logic [WADDR_W-1:0] word_idx;
    logic [1:0]         lane_off;
    logic [LANES-1:0]   steer_be;
    logic [DATA_W-1:0]  steer_wdata;
    logic               resv_valid;
    logic               resv_hit;
    logic               cond_pass;
    logic [DATA_W-1:0]  load_value;

    ret_state_e         state_q;
    ret_state_e         state_d;
    acc_size_e          pend_size;
    logic [1:0]         pend_off;
    logic [RIDX_W-1:0]  pend_dst;
    logic               pend_ok;

    assign dec    = decode_op(req_op);
    assign req_ok = req_valid && dec.legal;

    lane_agen #(.WADDR_W(WADDR_W)) u_agen (
        .base     (req_base),
        .ofs      (req_ofs),
        .word_idx (word_idx),
        .lane_off (lane_off)
    );

    lane_store_steer u_steer (
        .size  (dec.size),
        .off   (lane_off),
        .src   (req_src),
        .be    (steer_be),
        .wdata (steer_wdata)
    );

    lane_resv #(.WADDR_W(WADDR_W)) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_set    (req_ok && dec.is_link),
        .cond_fire   (req_ok && dec.is_cond),
        .plain_store (req_ok && dec.is_store && !dec.is_cond),
        .kill        (resv_kill),
        .probe       (word_idx),
        .valid       (resv_valid),
        .hit         (resv_hit)
    );

    assign cond_pass = req_ok && dec.is_cond && resv_hit && !resv_kill;

    // memory request, same cycle as the request
    always_comb begin
        mem_en    = req_ok && (!dec.is_cond || cond_pass);
        mem_we    = mem_en && dec.is_store;
        mem_addr  = word_idx;
        mem_be    = dec.is_store ? steer_be : 4'hF;
        mem_wdata = dec.is_store ? steer_wdata : '0;
    end

    // next writeback kind
    always_comb begin
        state_d = ST_IDLE;
        if (req_ok) begin
            if (dec.is_load)      state_d = ST_LOAD_RET;
            else if (dec.is_cond) state_d = ST_COND_RET;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // context of the pending writeback
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_size <= ACC_WORD;
            pend_off  <= '0;
            pend_dst  <= '0;
            pend_ok   <= 1'b0;
        end else if (req_ok) begin
            pend_size <= dec.size;
            pend_off  <= lane_off;
            pend_dst  <= req_dst;
            pend_ok   <= cond_pass;
        end
    end

    lane_load_align u_align (
        .size  (pend_size),
        .off   (pend_off),
        .rdata (mem_rdata),
        .value (load_value)
    );

    // writeback outputs
    always_comb begin
        wb_dst = pend_dst;
        unique case (state_q)
            ST_LOAD_RET: begin
                wb_en   = 1'b1;
                wb_data = load_value;
            end
            ST_COND_RET: begin
                wb_en   = 1'b1;
                wb_data = {31'b0, pend_ok};
            end
            default: begin
                wb_en   = 1'b0;
                wb_data = '0;
            end
        endcase
    end
endmodule

// File: rtl/lane_lsu_chk.sv
module lane_lsu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [5:0]  req_op,
    input logic        resv_kill,
    input logic        mem_en,
    input logic        mem_we,
    input logic [3:0]  mem_be,
    input logic        wb_en,
    input logic [30:0] wb_hi,
    input logic        resv_valid
);
    import lane_lsu_pkg::*;

    logic any_load;
    assign any_load = req_valid && (req_op == OPC_LBU || req_op == OPC_LHU ||
                                    req_op == OPC_LW  || req_op == OPC_LL);

    // R13
    idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !mem_en);

    // R13
    idle_no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !wb_en);

    // R2
    byte_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OPC_SB) |-> (mem_we && $countones(mem_be) == 1));

    // R3
    half_pair_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OPC_SH) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

    // R5
    load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_load |=> wb_en);

    // R5
    load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_load |-> !mem_we);

    // R9
    cond_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OPC_SC) |=> (wb_en && wb_hi == '0));

    // R9
    cond_no_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OPC_SC && !resv_valid) |-> !mem_we);

    // R8
    link_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OPC_LL) |=> resv_valid);

    // R10
    cond_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OPC_SC) |=> !resv_valid);

    // R12
    kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_kill && !(req_valid && req_op == OPC_LL)) |=> !resv_valid);
endmodule

bind lane_lsu lane_lsu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .resv_kill  (resv_kill),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .wb_en      (wb_en),
    .wb_hi      (wb_data[31:1]),
    .resv_valid (resv_valid)
);

// File: tb/lane_lsu_bench.sv
`timescale 1ns/1ps
module lane_lsu_bench;
    localparam int WA = 8;
    localparam int RI = 5;

    localparam logic [5:0] LBU = 6'h24, LHU = 6'h25, LW = 6'h23, SB = 6'h28,
                           SH  = 6'h29, SW  = 6'h2b, LL = 6'h30, SC = 6'h38;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [5:0]    req_op = '0;
    logic [31:0]   req_base = '0;
    logic [31:0]   req_src = '0;
    logic [15:0]   req_ofs = '0;
    logic [RI-1:0] req_dst = '0;
    logic          resv_kill = 1'b0;
    logic          mem_en, mem_we;
    logic [WA-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;
    logic          wb_en;
    logic [RI-1:0] wb_dst;
    logic [31:0]   wb_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic          c_en, c_we;
    logic [WA-1:0] c_addr;
    logic [3:0]    c_be;
    logic [31:0]   c_wdata;
    logic          r_en;
    logic [RI-1:0] r_dst;
    logic [31:0]   r_data;

    always #2 clk = ~clk;

    lane_lsu #(.WADDR_W(WA), .RIDX_W(RI)) u_lane_lsu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_src(req_src), .req_ofs(req_ofs), .req_dst(req_dst),
        .resv_kill(resv_kill), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wb_en(wb_en), .wb_dst(wb_dst), .wb_data(wb_data)
    );

    function automatic logic [31:0] pat(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b, ~b, b ^ 8'h5A, 8'hC3};
    endfunction

    // memory model: one-cycle read latency, byte-enabled writes
    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) mem[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one request, then one idle cycle; captures request and writeback outputs
    task automatic issue(input logic v, input logic [5:0] op, input logic [31:0] base,
                         input logic [31:0] src, input logic [15:0] ofs,
                         input logic [RI-1:0] dst, input logic kill);
        @(negedge clk);
        req_valid = v; req_op = op; req_base = base; req_src = src;
        req_ofs = ofs; req_dst = dst; resv_kill = kill;
        #1;
        c_en = mem_en; c_we = mem_we; c_addr = mem_addr; c_be = mem_be; c_wdata = mem_wdata;
        @(negedge clk);
        req_valid = 1'b0; resv_kill = 1'b0;
        #1;
        r_en = wb_en; r_dst = wb_dst; r_data = wb_data;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R14 mem_en after reset", 32'(mem_en), 0);
        chk("R14 wb_en after reset", 32'(wb_en), 0);
        issue(1, SC, 32'h0, 32'h5555_5555, 16'h0, 5'd3, 0);
        chk("R14 sc with no reservation mem_en", 32'(c_en), 0);
        chk("R14 sc with no reservation flag", r_data, 0);
    endtask

    task automatic t_address;
        issue(1, LW, 32'h100, 32'h0, 16'hFFFC, 5'd9, 0);
        chk("R1 mem_en", 32'(c_en), 1);
        chk("R1 negative offset index", 32'(c_addr), 32'h3F);
        chk("R5 lw no write", 32'(c_we), 0);
        chk("R5 lw wb_en", 32'(r_en), 1);
        chk("R5 lw wb_dst", 32'(r_dst), 9);
        chk("R5 lw data", r_data, pat(8'h3F));
        issue(1, LW, 32'h1000_0000, 32'h0, 16'h7FFC, 5'd2, 0);
        chk("R1 positive offset index", 32'(c_addr), 32'hFF);
        chk("R5 lw data high word", r_data, pat(8'hFF));
    endtask

    task automatic t_subword_loads;
        for (int k = 0; k < 4; k++) begin
            issue(1, LBU, 32'h50, 32'h0, 16'(32'hFFF0 + k), 5'd4, 0);
            chk("R6 lbu lane", r_data, {24'b0, pat(8'h10)[8*k +: 8]});
        end
        issue(1, LHU, 32'h40, 32'h0, 16'h0, 5'd5, 0);
        chk("R7 lhu low half", r_data, {16'b0, pat(8'h10)[15:0]});
        issue(1, LHU, 32'h42, 32'h0, 16'h0, 5'd5, 0);
        chk("R7 lhu high half", r_data, {16'b0, pat(8'h10)[31:16]});
        // back-to-back: lbu then lw
        @(negedge clk);
        req_valid = 1; req_op = LBU; req_base = 32'h41; req_ofs = 16'h0; req_dst = 5'd6;
        @(negedge clk);
        req_op = LW; req_base = 32'h40; req_dst = 5'd7;
        #1;
        chk("R5 pipelined lbu data", wb_data, {24'b0, pat(8'h10)[15:8]});
        chk("R5 pipelined lbu dst", 32'(wb_dst), 6);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk("R5 pipelined lw data", wb_data, pat(8'h10));
        chk("R5 pipelined lw dst", 32'(wb_dst), 7);
    endtask

    task automatic t_stores;
        issue(1, SB, 32'h81, 32'h1234_565A, 16'h0, 5'd0, 0);
        chk("R2 sb we", 32'(c_we), 1);
        chk("R2 sb be", 32'(c_be), 32'h2);
        chk("R2 sb wdata", c_wdata, 32'h5A5A_5A5A);
        chk("R13 no writeback after store", 32'(r_en), 0);
        issue(1, SH, 32'h82, 32'hAAAA_1234, 16'h0, 5'd0, 0);
        chk("R3 sh high be", 32'(c_be), 32'hC);
        chk("R3 sh wdata", c_wdata, 32'h1234_1234);
        issue(1, LW, 32'h80, 32'h0, 16'h0, 5'd1, 0);
        chk("R3 sb+sh merged word", r_data, 32'h1234_5AC3);
        issue(1, SW, 32'h80, 32'hCAFE_F00D, 16'h0, 5'd0, 0);
        chk("R4 sw be", 32'(c_be), 32'hF);
        chk("R4 sw wdata", c_wdata, 32'hCAFE_F00D);
        issue(1, SH, 32'h80, 32'h0000_BEEF, 16'h0, 5'd0, 0);
        chk("R3 sh low be", 32'(c_be), 32'h3);
        issue(1, LW, 32'h80, 32'h0, 16'h0, 5'd1, 0);
        chk("R4 word after sw and sh", r_data, 32'hCAFE_BEEF);
    endtask

    task automatic t_link_pair;
        issue(1, LL, 32'hC0, 32'h0, 16'h0, 5'd8, 0);
        chk("R5 ll returns word", r_data, pat(8'h30));
        issue(1, SC, 32'hC0, 32'h1111_2222, 16'h0, 5'd7, 0);
        chk("R8 sc success we", 32'(c_we), 1);
        chk("R8 sc be", 32'(c_be), 32'hF);
        chk("R8 sc wdata", c_wdata, 32'h1111_2222);
        chk("R8 sc dst", 32'(r_dst), 7);
        chk("R8 sc flag one", r_data, 1);
        issue(1, SC, 32'hC0, 32'h3333_4444, 16'h0, 5'd7, 0);
        chk("R10 second sc mem_en", 32'(c_en), 0);
        chk("R9 failed sc wb_en", 32'(r_en), 1);
        chk("R9 failed sc flag", r_data, 0);
        issue(1, LW, 32'hC0, 32'h0, 16'h0, 5'd1, 0);
        chk("R9 memory holds first sc value", r_data, 32'h1111_2222);
        issue(1, LL, 32'hC0, 32'h0, 16'h0, 5'd8, 0);
        issue(1, SC, 32'h4C0, 32'h0, 16'h0, 5'd7, 0);
        chk("R8 aliased index succeeds", r_data, 1);
    endtask

    task automatic t_store_clear;
        issue(1, LL, 32'hC0, 32'h0, 16'h0, 5'd8, 0);
        issue(1, SW, 32'hC4, 32'h9, 16'h0, 5'd0, 0);
        issue(1, SC, 32'hC0, 32'h7, 16'h0, 5'd7, 0);
        chk("R11 other-word store keeps reservation", r_data, 1);
        issue(1, LL, 32'hC0, 32'h0, 16'h0, 5'd8, 0);
        issue(1, SB, 32'hC3, 32'h9, 16'h0, 5'd0, 0);
        issue(1, SC, 32'hC0, 32'h7, 16'h0, 5'd7, 0);
        chk("R11 same-word sb clears", r_data, 0);
        chk("R11 failed sc no access", 32'(c_en), 0);
    endtask

    task automatic t_kill;
        issue(1, LL, 32'hC0, 32'h0, 16'h0, 5'd8, 0);
        issue(0, LW, 32'h0, 32'h0, 16'h0, 5'd0, 1);
        issue(1, SC, 32'hC0, 32'h7, 16'h0, 5'd7, 0);
        chk("R12 kill pulse clears", r_data, 0);
        issue(1, LL, 32'hC0, 32'h0, 16'h0, 5'd8, 1);
        issue(1, SC, 32'hC0, 32'h7, 16'h0, 5'd7, 0);
        chk("R12 ll wins over kill", r_data, 1);
        issue(1, LL, 32'hC0, 32'h0, 16'h0, 5'd8, 0);
        issue(1, SC, 32'hC0, 32'h7, 16'h0, 5'd7, 1);
        chk("R8 kill during sc fails", r_data, 0);
        chk("R8 kill during sc no access", 32'(c_en), 0);
    endtask

    task automatic t_ignored;
        issue(1, LL, 32'hC0, 32'h0, 16'h0, 5'd8, 0);
        issue(1, 6'h3F, 32'hC0, 32'h0, 16'h0, 5'd3, 0);
        chk("R13 unknown op mem_en", 32'(c_en), 0);
        chk("R13 unknown op wb_en", 32'(r_en), 0);
        issue(0, SW, 32'hC0, 32'h0, 16'h0, 5'd3, 0);
        chk("R13 invalid request mem_en", 32'(c_en), 0);
        chk("R13 invalid request wb_en", 32'(r_en), 0);
        issue(1, SC, 32'hC0, 32'h7, 16'h0, 5'd7, 0);
        chk("R13 reservation untouched", r_data, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog R14 act=%0d exp=%0d", cyc, 5000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_address();
        t_subword_loads();
        t_stores();
        t_link_pair();
        t_store_clear();
        t_kill();
        t_ignored();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule